// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block sits between software and a small cluster of processors. It holds a bank of common interrupts and decides which processor lines each one drives. Software controls it through two registers. The first is a parameter register, which software can write and read back. The second is a command word. Writing the command word runs one operation on the interrupt it names. Some operations take their argument from the parameter register. Read operations leave their result there.

Each common interrupt has three settings. A target set says which processors may receive it. A delivery policy picks one of four choices: none, rotating, first taker, or broadcast. A trigger style is either level or pulse. A processor reports that it has serviced an interrupt through a per-line take strobe. That processor's entry then leaves the pending set. The service becomes visible as an acknowledgement only after software issues a clear. A global enable gates every output line. Asserts made while the unit is off are still recorded as pending.

Top module: `irq_distributor`

## Requirements
- R1: After reset, the unit is disabled and every target set, policy and trigger is zero. All output lines are low and the parameter register reads 0. Command 0x01 turns the unit on and command 0x00 turns it off. Neither command depends on the interrupt number.
- R2: A command word holds the operation code in bits 7:0 and the interrupt number in bits 15:8. Code 0x09 copies the low NUM_CPU bits of the parameter register into the target set, and 0x0A reads the target set back. Code 0x04 stores the policy from parameter bits 7:0 and the trigger from bit 15. Code 0x08 reads them back in the same positions.
- R3: Policy 3 with level trigger (bit 15 = 0), then assert (0x03), raises the line of every processor in the target set. The lines stay high until clear (0x02).
- R4: With pulse trigger (bit 15 = 1), each assert drives each chosen line high for exactly one cycle.
- R5: Policy 1 delivers each assert to one processor. The chosen processors rotate upward through the target set, skip processors outside it, and wrap around.
- R6: Policy 2 marks every processor in the target set pending. The first take by any of them clears the pending state for all of them.
- R7: Code 0x07 returns the pending set: recipients of an assert that have not yet taken it. A take strobe removes that processor from the set.
- R8: Code 0x06 returns the acknowledge set. A clear adds to it every processor that took the interrupt. A new assert removes its recipients from it.
- R9: Code 0x05 returns status. Bit 0 is the unit enable, bit 1 is asserted, bit 2 is any acknowledge, bit 3 is any pending. Bits 15:8 give the processor the next rotating delivery would pick.
- R10: While the unit is disabled, asserts still update the pending set, but every output line stays low. Policy 0 delivers to no processor.
- R11: A command whose interrupt number is NUM_IRQ or above is ignored, except 0x00 and 0x01. Any code above 0x0A is also ignored. The parameter register stays unchanged in both cases.
- R12: A software write to the parameter register shows on its output one cycle later. A read command's result replaces the register in the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Interrupt number [15:8], operation code [7:0] |
| prm_we | input | 1 | Parameter register write strobe |
| prm_wdata | input | PRM_W | Parameter write data |
| cpu_take | input | NUM_CPU*NUM_IRQ | Take strobe, bit cpu*NUM_IRQ+irq |
| prm_rdata | output | PRM_W | Parameter register contents |
| cpu_irq | output | NUM_CPU*NUM_IRQ | Interrupt line, bit cpu*NUM_IRQ+irq |

## Verification
Delivery is exercised with four target sets against the four policies. A two-processor set under broadcast separates level holding from pulse timing. A sparse three-processor set under rotation shows that a processor outside the set is skipped and the pointer wraps. A full set under first-taker shows that one take clears every pending bit but acknowledges only the taker. Repeating an assert with the unit off, with policy 0, with an out-of-range number, and with an unknown code separates recording from driving and shows which commands are ignored.

// File: rtl/irqd_pkg.sv
// Shared codes for the interrupt distributor.
// Assumes the command and status encodings below are fixed by software.
package irqd_pkg;

    typedef enum logic [7:0] {
        OP_UNIT_OFF = 8'h00,
        OP_UNIT_ON  = 8'h01,
        OP_CLEAR    = 8'h02,
        OP_ASSERT   = 8'h03,
        OP_WMODE    = 8'h04,
        OP_RSTATUS  = 8'h05,
        OP_RACK     = 8'h06,
        OP_RPEND    = 8'h07,
        OP_RMODE    = 8'h08,
        OP_WMASK    = 8'h09,
        OP_RMASK    = 8'h0A
    } irqd_op_e;

    localparam logic [7:0] DEST_NONE   = 8'd0;
    localparam logic [7:0] DEST_ROTATE = 8'd1;
    localparam logic [7:0] DEST_FIRST  = 8'd2;
    localparam logic [7:0] DEST_ALL    = 8'd3;

    localparam int TRIG_BIT     = 15;
    localparam int ST_EN_BIT    = 0;
    localparam int ST_ASSERTED  = 1;
    localparam int ST_ACK_BIT   = 2;
    localparam int ST_PEND_BIT  = 3;
    localparam int ST_NEXT_LSB  = 8;

endpackage

// File: rtl/irqd_cmd_decode.sv
// Splits a command word into operation, interrupt number and a one-hot
// select of the addressed interrupt. Assumes NUM_IRQ <= 256.
module irqd_cmd_decode #(
    parameter int NUM_IRQ = 16
) (
    input  logic               cmd_we,
    input  logic [15:0]        cmd_word,
    output logic [7:0]         op,
    output logic [7:0]         irq_num,
    output logic               irq_ok,
    output logic               is_read,
    output logic               unit_on,
    output logic               unit_off,
    output logic [NUM_IRQ-1:0] hit
);
    import irqd_pkg::*;

    logic per_irq_op;

    // Field extraction and range checks.
    always_comb begin
        op         = cmd_word[7:0];
        irq_num    = cmd_word[15:8];
        irq_ok     = (int'(irq_num) < NUM_IRQ);
        per_irq_op = (op >= OP_CLEAR) && (op <= OP_RMASK);
        is_read    = cmd_we && irq_ok && (op == OP_RSTATUS || op == OP_RACK ||
                     op == OP_RPEND || op == OP_RMODE || op == OP_RMASK);
        unit_on    = cmd_we && (op == OP_UNIT_ON);
        unit_off   = cmd_we && (op == OP_UNIT_OFF);
    end

    // One select per interrupt.
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_hit
        assign hit[i] = cmd_we && irq_ok && per_irq_op && (int'(irq_num) == i);
    end

endmodule

// File: rtl/irqd_rr_pick.sv
// Finds the first target at or after a pointer (cyclic) and the target
// after that one. Assumes NUM_CPU >= 2.
module irqd_rr_pick #(
    parameter int NUM_CPU = 4,
    localparam int PW = $clog2(NUM_CPU)
) (
    input  logic [NUM_CPU-1:0] mask,
    input  logic [PW-1:0]      ptr,
    output logic [PW-1:0]      cand,
    output logic               cand_ok,
    output logic [PW-1:0]      nxt
);
    // Cyclic search from ptr, then from cand+1.
    always_comb begin
        int idx;
        logic got;
        cand    = ptr;
        cand_ok = 1'b0;
        for (int k = 0; k < NUM_CPU; k++) begin
            idx = int'(ptr) + k;
            if (idx >= NUM_CPU) idx = idx - NUM_CPU;
            if (!cand_ok && mask[idx]) begin
                cand    = PW'(idx);
                cand_ok = 1'b1;
            end
        end
        nxt = cand;
        got = 1'b0;
        for (int k = 1; k <= NUM_CPU; k++) begin
            idx = int'(cand) + k;
            if (idx >= NUM_CPU) idx = idx - NUM_CPU;
            if (!got && mask[idx]) begin
                nxt = PW'(idx);
                got = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqd_line.sv
// State and delivery for one common interrupt: target set, policy, trigger,
// pending/taken/acknowledge sets, held level lines and the rotation pointer.
// Assumes hit is a single-cycle strobe and NUM_CPU <= 32.
module irqd_line #(
    parameter int NUM_CPU = 4,
    localparam int PW = $clog2(NUM_CPU)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unit_en,
    input  logic               hit,
    input  logic [7:0]         op,
    input  logic [31:0]        prm,
    input  logic [NUM_CPU-1:0] take,
    output logic [NUM_CPU-1:0] line_o,
    output logic [NUM_CPU-1:0] mask_o,
    output logic [7:0]         dest_o,
    output logic               trig_o,
    output logic [NUM_CPU-1:0] pend_o,
    output logic [NUM_CPU-1:0] ack_o,
    output logic               asserted_o,
    output logic [PW-1:0]      next_o
);
    import irqd_pkg::*;

    logic [NUM_CPU-1:0] mask_q, pend_q, ack_q, taken_q, held_q, pulse_q;
    logic [7:0]         dest_q;
    logic               trig_q, asserted_q;
    logic [PW-1:0]      ptr_q, cand, nxt;
    logic               cand_ok;
    logic [NUM_CPU-1:0] rcp, got, pend_tk;

    irqd_rr_pick #(.NUM_CPU(NUM_CPU)) u_pick (
        .mask(mask_q), .ptr(ptr_q), .cand(cand), .cand_ok(cand_ok), .nxt(nxt)
    );

    // Recipient set for an assert under the current policy.
    always_comb begin
        rcp = '0;
        case (dest_q)
            DEST_ROTATE: if (cand_ok) rcp[cand] = 1'b1;
            DEST_FIRST,
            DEST_ALL:    rcp = mask_q;
            default:     rcp = '0;
        endcase
    end

    // Effect of take strobes on the pending set.
    always_comb begin
        got     = take & pend_q;
        pend_tk = ((dest_q == DEST_FIRST) && (|got)) ? '0 : (pend_q & ~got);
    end

    // Per-interrupt state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q     <= '0;
            dest_q     <= '0;
            trig_q     <= 1'b0;
            pend_q     <= '0;
            ack_q      <= '0;
            taken_q    <= '0;
            held_q     <= '0;
            pulse_q    <= '0;
            asserted_q <= 1'b0;
            ptr_q      <= '0;
        end else begin
            pulse_q <= '0;
            pend_q  <= pend_tk;
            taken_q <= taken_q | got;
            if (hit) begin
                case (op)
                    OP_CLEAR: begin
                        ack_q      <= ack_q | taken_q | got;
                        taken_q    <= '0;
                        held_q     <= '0;
                        pend_q     <= '0;
                        asserted_q <= 1'b0;
                    end
                    OP_ASSERT: begin
                        pend_q     <= pend_tk | rcp;
                        ack_q      <= ack_q & ~rcp;
                        taken_q    <= (taken_q | got) & ~rcp;
                        asserted_q <= 1'b1;
                        if (trig_q) pulse_q <= unit_en ? rcp : '0;
                        else        held_q  <= held_q | rcp;
                        if (dest_q == DEST_ROTATE && cand_ok) ptr_q <= nxt;
                    end
                    OP_WMODE: begin
                        dest_q <= prm[7:0];
                        trig_q <= prm[TRIG_BIT];
                    end
                    OP_WMASK: mask_q <= prm[NUM_CPU-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Output lines and readback.
    always_comb begin
        line_o     = trig_q ? pulse_q : (unit_en ? held_q : '0);
        mask_o     = mask_q;
        dest_o     = dest_q;
        trig_o     = trig_q;
        pend_o     = pend_q;
        ack_o      = ack_q;
        asserted_o = asserted_q;
        next_o     = cand_ok ? cand : ptr_q;
    end

endmodule

// File: rtl/irq_distributor.sv
// Top of the interrupt distributor: command decode, unit enable, the
// parameter register, one irqd_line per common interrupt and the read mux.
// Assumes 2 <= NUM_CPU <= 32, NUM_IRQ <= 256, PRM_W = 32.
module irq_distributor #(
    parameter int NUM_IRQ = 16,
    parameter int NUM_CPU = 4,
    parameter int PRM_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_we,
    input  logic [15:0]                cmd_word,
    input  logic                       prm_we,
    input  logic [PRM_W-1:0]           prm_wdata,
    input  logic [NUM_CPU*NUM_IRQ-1:0] cpu_take,
    output logic [PRM_W-1:0]           prm_rdata,
    output logic [NUM_CPU*NUM_IRQ-1:0] cpu_irq
);
    import irqd_pkg::*;

    localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int PW = $clog2(NUM_CPU);

    logic [7:0]         op, irq_num;
    logic               irq_ok, is_read, unit_on, unit_off;
    logic [NUM_IRQ-1:0] hit;
    logic               en_q;
    logic [PRM_W-1:0]   prm_q, rd_val;
    logic [IW-1:0]      sel;

    logic [NUM_CPU-1:0] take_a [NUM_IRQ];
    logic [NUM_CPU-1:0] line_a [NUM_IRQ];
    logic [NUM_CPU-1:0] mask_a [NUM_IRQ];
    logic [NUM_CPU-1:0] pend_a [NUM_IRQ];
    logic [NUM_CPU-1:0] ack_a  [NUM_IRQ];
    logic [7:0]         dest_a [NUM_IRQ];
    logic [PW-1:0]      next_a [NUM_IRQ];
    logic [NUM_IRQ-1:0] trig_v, asrt_v;

    irqd_cmd_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
        .cmd_we(cmd_we), .cmd_word(cmd_word), .op(op), .irq_num(irq_num),
        .irq_ok(irq_ok), .is_read(is_read), .unit_on(unit_on),
        .unit_off(unit_off), .hit(hit)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            assign take_a[i][c]          = cpu_take[c*NUM_IRQ + i];
            assign cpu_irq[c*NUM_IRQ + i] = line_a[i][c];
        end
        irqd_line #(.NUM_CPU(NUM_CPU)) u_line (
            .clk(clk), .rst_n(rst_n), .unit_en(en_q), .hit(hit[i]), .op(op),
            .prm(prm_q), .take(take_a[i]), .line_o(line_a[i]),
            .mask_o(mask_a[i]), .dest_o(dest_a[i]), .trig_o(trig_v[i]),
            .pend_o(pend_a[i]), .ack_o(ack_a[i]), .asserted_o(asrt_v[i]),
            .next_o(next_a[i])
        );
    end

    // Result of a read command for the addressed interrupt.
    always_comb begin
        sel    = irq_ok ? irq_num[IW-1:0] : '0;
        rd_val = '0;
        case (op)
            OP_RSTATUS: begin
                rd_val[ST_EN_BIT]   = en_q;
                rd_val[ST_ASSERTED] = asrt_v[sel];
                rd_val[ST_ACK_BIT]  = |ack_a[sel];
                rd_val[ST_PEND_BIT] = |pend_a[sel];
                rd_val[ST_NEXT_LSB +: PW] = next_a[sel];
            end
            OP_RACK:  rd_val[NUM_CPU-1:0] = ack_a[sel];
            OP_RPEND: rd_val[NUM_CPU-1:0] = pend_a[sel];
            OP_RMODE: begin
                rd_val[7:0]      = dest_a[sel];
                rd_val[TRIG_BIT] = trig_v[sel];
            end
            OP_RMASK: rd_val[NUM_CPU-1:0] = mask_a[sel];
            default:  rd_val = '0;
        endcase
    end

    // Unit enable and parameter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            prm_q <= '0;
        end else begin
            if (unit_on)       en_q <= 1'b1;
            else if (unit_off) en_q <= 1'b0;
            if (is_read)       prm_q <= rd_val;
            else if (prm_we)   prm_q <= prm_wdata;
        end
    end

    assign prm_rdata = prm_q;

endmodule

// File: rtl/irqd_checker.sv
// Temporal checks on the distributor's ports and enable state.
module irqd_checker #(
    parameter int NUM_IRQ = 16,
    parameter int NUM_CPU = 4,
    parameter int PRM_W   = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmd_we,
    input logic [15:0]                cmd_word,
    input logic                       prm_we,
    input logic [PRM_W-1:0]           prm_wdata,
    input logic [PRM_W-1:0]           prm_rdata,
    input logic [NUM_CPU*NUM_IRQ-1:0] cpu_irq,
    input logic                       unit_en
);
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |-> cpu_irq == '0); // R10

    AST_OFF_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_word[7:0] == 8'h00) |=> cpu_irq == '0); // R1

    AST_PRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we && !prm_we) |=> $stable(prm_rdata)); // R12

    AST_PRM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (prm_we && !cmd_we) |=> prm_rdata == $past(prm_wdata)); // R12

    AST_BAD_IRQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !prm_we && int'(cmd_word[15:8]) >= NUM_IRQ) |=> $stable(prm_rdata)); // R11

    AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !prm_we && cmd_word[7:0] > 8'h0A) |=> $stable(prm_rdata)); // R11

endmodule

bind irq_distributor irqd_checker #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRM_W(PRM_W)
) u_irqd_checker (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .prm_we(prm_we), .prm_wdata(prm_wdata), .prm_rdata(prm_rdata),
    .cpu_irq(cpu_irq), .unit_en(en_q)
);

// File: tb/test_irq_distributor.sv
// Scoreboard bench: driver tasks push expectations, a negedge monitor pops
// and compares them against the ports.
module test_irq_distributor;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 16;
    localparam int NC = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_we = 1'b0;
    logic [15:0]       cmd_word = '0;
    logic              prm_we = 1'b0;
    logic [31:0]       prm_wdata = '0;
    logic [NC*NI-1:0]  cpu_take = '0;
    logic [31:0]       prm_rdata;
    logic [NC*NI-1:0]  cpu_irq;

    typedef struct {
        string       req;
        bit          is_line;
        logic [63:0] exp;
    } item_t;

    item_t sbq[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    irq_distributor #(.NUM_IRQ(NI), .NUM_CPU(NC), .PRM_W(32)) i_irq_distributor (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .prm_we(prm_we), .prm_wdata(prm_wdata), .cpu_take(cpu_take),
        .prm_rdata(prm_rdata), .cpu_irq(cpu_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare every queued expectation at the falling edge.
    always @(negedge clk) begin
        item_t it;
        logic [63:0] act;
        while (sbq.size() > 0) begin
            it  = sbq.pop_front();
            act = it.is_line ? 64'(cpu_irq) : {32'b0, prm_rdata};
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    function automatic logic [63:0] lb(int c, int i);
        return 64'b1 << (c*NI + i);
    endfunction

    task automatic exp_prm(string req, logic [31:0] v);
        sbq.push_back('{req, 1'b0, {32'b0, v}});
    endtask

    task automatic exp_lines(string req, logic [63:0] v);
        sbq.push_back('{req, 1'b1, v});
    endtask

    task automatic cmd(logic [7:0] irq, logic [7:0] op);
        @(negedge clk);
        cmd_we   = 1'b1;
        cmd_word = {irq, op};
        @(posedge clk); #1;
        cmd_we   = 1'b0;
    endtask

    task automatic wprm(logic [31:0] v);
        @(negedge clk);
        prm_we    = 1'b1;
        prm_wdata = v;
        @(posedge clk); #1;
        prm_we    = 1'b0;
    endtask

    task automatic take(int c, int i);
        @(negedge clk);
        cpu_take[c*NI + i] = 1'b1;
        @(posedge clk); #1;
        cpu_take = '0;
    endtask

    task automatic idle();
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic setup(logic [7:0] irq, logic [31:0] msk, logic [31:0] mode);
        wprm(msk);  cmd(irq, 8'h09);
        wprm(mode); cmd(irq, 8'h04);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD*50000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        exp_prm("R1 reset prm", 32'h0);
        exp_lines("R1 reset lines", 64'h0);

        // R1 / R9: enable, status of idle irq0
        cmd(8'd0, 8'h01);
        cmd(8'd0, 8'h05);
        exp_prm("R9 status idle", 32'h0000_0001);

        // R2 / R12: target set and mode round trip on irq 3
        wprm(32'hA);
        exp_prm("R12 prm write", 32'hA);
        cmd(8'd3, 8'h09);
        wprm(32'h0);
        cmd(8'd3, 8'h0A);
        exp_prm("R2 read mask", 32'hA);
        wprm(32'h8003);
        cmd(8'd3, 8'h04);
        wprm(32'h0);
        cmd(8'd3, 8'h08);
        exp_prm("R2 read mode", 32'h8003);

        // R3 level broadcast on irq 5 to cpus 0 and 2
        setup(8'd5, 32'h5, 32'h0003);
        cmd(8'd5, 8'h03);
        exp_lines("R3 level raise", lb(0,5) | lb(2,5));
        idle();
        exp_lines("R3 level hold", lb(0,5) | lb(2,5));
        cmd(8'd5, 8'h07);
        exp_prm("R7 pend both", 32'h5);
        take(0, 5);
        cmd(8'd5, 8'h07);
        exp_prm("R7 pend after take", 32'h4);
        cmd(8'd5, 8'h02);
        exp_lines("R3 clear drops", 64'h0);
        cmd(8'd5, 8'h06);
        exp_prm("R8 ack taker", 32'h1);
        cmd(8'd5, 8'h05);
        exp_prm("R9 status after clear", 32'h0000_0005);

        // R4 pulse broadcast on irq 3 to cpus 1 and 3
        cmd(8'd3, 8'h03);
        exp_lines("R4 pulse high", lb(1,3) | lb(3,3));
        idle();
        exp_lines("R4 pulse gone", 64'h0);
        cmd(8'd3, 8'h03);
        exp_lines("R4 second pulse", lb(1,3) | lb(3,3));
        idle();
        exp_lines("R4 second gone", 64'h0);
        cmd(8'd3, 8'h02);

        // R5 rotation on irq 7, target set cpus 0,2,3, pulse trigger
        setup(8'd7, 32'hD, 32'h8001);
        cmd(8'd7, 8'h03);
        exp_lines("R5 rot cpu0", lb(0,7));
        cmd(8'd7, 8'h05);
        exp_prm("R9 status next cpu2", 32'h0000_020B);
        cmd(8'd7, 8'h03);
        exp_lines("R5 rot cpu2", lb(2,7));
        cmd(8'd7, 8'h03);
        exp_lines("R5 rot cpu3", lb(3,7));
        cmd(8'd7, 8'h03);
        exp_lines("R5 rot wrap cpu0", lb(0,7));
        cmd(8'd7, 8'h02);

        // R6 first taker on irq 9, all cpus, level
        setup(8'd9, 32'hF, 32'h0002);
        cmd(8'd9, 8'h03);
        exp_lines("R6 all lines", lb(0,9) | lb(1,9) | lb(2,9) | lb(3,9));
        cmd(8'd9, 8'h07);
        exp_prm("R6 pend all", 32'hF);
        take(2, 9);
        cmd(8'd9, 8'h07);
        exp_prm("R6 pend dropped", 32'h0);
        cmd(8'd9, 8'h02);
        cmd(8'd9, 8'h06);
        exp_prm("R8 ack first taker", 32'h4);
        cmd(8'd9, 8'h03);
        cmd(8'd9, 8'h06);
        exp_prm("R8 reassert clears ack", 32'h0);
        cmd(8'd9, 8'h02);
        exp_lines("R6 cleared", 64'h0);

        // R10 disabled unit, then policy 0
        cmd(8'd0, 8'h00);
        setup(8'd11, 32'h3, 32'h0003);
        cmd(8'd11, 8'h03);
        exp_lines("R10 off no lines", 64'h0);
        cmd(8'd11, 8'h07);
        exp_prm("R10 off pend recorded", 32'h3);
        cmd(8'd0, 8'h01);
        exp_lines("R10 on shows level", lb(0,11) | lb(1,11));
        cmd(8'd11, 8'h02);
        exp_lines("R10 clear", 64'h0);
        setup(8'd12, 32'hF, 32'h0000);
        cmd(8'd12, 8'h03);
        exp_lines("R10 policy0 no lines", 64'h0);
        cmd(8'd12, 8'h07);
        exp_prm("R10 policy0 no pend", 32'h0);

        // R11 out of range number and unknown code
        wprm(32'h1234);
        cmd(8'd20, 8'h0A);
        exp_prm("R11 bad irq ignored", 32'h1234);
        cmd(8'd3, 8'h0B);
        exp_prm("R11 bad op ignored", 32'h1234);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule